// File: doc/BRIEF.md
# Duty-Cycled Wake-Up Power Sequencer

This block is the top-level controller of a duty-cycled wake-up receiver. It spends most of its time asleep, counting a programmable sleep interval with every front-end enable low and the slow clock selected. When the interval expires it brings the analog chain up in a fixed order. The baseband amplifier comes first and gets its own settle time. The RF amplifier and the comparator follow together and get a second settle time. The clock is then switched to fast mode, which costs a fixed delay. Only after that does a short listening window open.

If the preamble detector reports no packet presence before the window closes, the detector is aborted, everything is powered down and the block sleeps again. A presence report holds the whole chain powered for as long as decoding takes, past the nominal window if needed. Decoding runs in two steps. The preamble detector finishes first. The address correlator then runs with the serial receiver enabled. When decoding ends, the outcome is recorded in a status register and all enables drop before the next sleep. An address match also raises a one-cycle wake interrupt for the host.

Every wait is a count of clock cycles, taken from configuration inputs.

Top module: `wake_sequencer`

## Requirements
- R1: After reset and after every return to sleep, all enables and fast_clk stay low for max(cfg_sleep,1) cycles.
- R2: On wake, bb_en rises alone and stays the only enable for cfg_bb_settle cycles.
- R3: rf_en and cmp_en rise in the same cycle and hold for cfg_rf_settle cycles before fast_clk rises.
- R4: fast_clk is high for cfg_clk_switch cycles before det_en rises, and stays high until the return to sleep.
- R5: A zero settle or switch count skips that stage, so its enables rise together with those of the next stage.
- R6: With no det_seen, det_en stays high for max(cfg_listen,1) cycles. All enables then drop, det_abort pulses for one cycle, and status becomes 1.
- R7: det_seen during the listening window, including its last cycle, keeps bb_en, rf_en, cmp_en and fast_clk high until decoding ends, however long that takes. det_seen outranks the window expiry.
- R8: det_fail while the preamble is still pending powers everything down and sets status to 2. det_fail outranks det_ok.
- R9: det_ok pulses corr_start for one cycle and raises uart_en. On corr_done, uart_en and all enables drop, and status becomes 4 with a one-cycle wake_irq if corr_match, or 3 otherwise.
- R10: Status encoding: 0 none since reset, 1 listen timeout, 2 preamble fail, 3 address mismatch, 4 address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sleep | input | CNT_W | Sleep interval in cycles (zero acts as one) |
| cfg_bb_settle | input | CNT_W | Baseband amplifier settle cycles |
| cfg_rf_settle | input | CNT_W | RF amplifier and comparator settle cycles |
| cfg_clk_switch | input | CNT_W | Clock switch delay cycles |
| cfg_listen | input | CNT_W | Listening window in cycles (zero acts as one) |
| det_seen | input | 1 | Preamble detector saw packet presence |
| det_ok | input | 1 | Preamble detector succeeded |
| det_fail | input | 1 | Preamble detector failed |
| corr_done | input | 1 | Address correlator finished |
| corr_match | input | 1 | Address matched (valid with corr_done) |
| bb_en | output | 1 | Baseband amplifier enable |
| rf_en | output | 1 | RF amplifier enable |
| cmp_en | output | 1 | Comparator enable |
| fast_clk | output | 1 | Fast clock mode select |
| det_en | output | 1 | Preamble detector enable |
| det_abort | output | 1 | One-cycle abort at listen timeout |
| corr_start | output | 1 | One-cycle correlator start |
| uart_en | output | 1 | Serial receiver enable |
| wake_irq | output | 1 | One-cycle wake interrupt on address match |
| status | output | 3 | Last outcome code |

## Verification
On every cycle, the assertions check that the block is fully quiet while asleep and that the serial receiver never runs without the whole chain powered. They also check that an abort or interrupt pulse coincides with powered-down enables and the matching status code, and that the listening count never passes the window. Only the bench scenarios can show the exact length of each phase for a given configuration. The same holds for stage skipping with zero counts, for the window being exceeded while decoding, and for det_seen winning over expiry on the window's last cycle.

// File: rtl/wake_sequencer.sv
module wake_sequencer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_sleep,
  input  logic [CNT_W-1:0] cfg_bb_settle,
  input  logic [CNT_W-1:0] cfg_rf_settle,
  input  logic [CNT_W-1:0] cfg_clk_switch,
  input  logic [CNT_W-1:0] cfg_listen,
  input  logic             det_seen,
  input  logic             det_ok,
  input  logic             det_fail,
  input  logic             corr_done,
  input  logic             corr_match,
  output logic             bb_en,
  output logic             rf_en,
  output logic             cmp_en,
  output logic             fast_clk,
  output logic             det_en,
  output logic             det_abort,
  output logic             corr_start,
  output logic             uart_en,
  output logic             wake_irq,
  output logic [2:0]       status
);

  typedef enum logic [2:0] {
    S_SLEEP, S_BB, S_RF, S_SW, S_LISTEN, S_PRE, S_CORR
  } state_t;

  localparam logic [2:0] ST_NONE = 3'd0, ST_TIMEOUT = 3'd1, ST_PREFAIL = 3'd2,
                         ST_MISS = 3'd3, ST_MATCH = 3'd4;

  state_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] limit;
  logic             expired;
  state_t           after_rf, after_bb, after_sleep;

  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign expired  = cnt_inc >= {1'b0, limit};

  assign after_rf    = (cfg_clk_switch != '0) ? S_SW : S_LISTEN;
  assign after_bb    = (cfg_rf_settle  != '0) ? S_RF : after_rf;
  assign after_sleep = (cfg_bb_settle  != '0) ? S_BB : after_bb;

  always_comb begin
    case (state)
      S_SLEEP:  limit = cfg_sleep;
      S_BB:     limit = cfg_bb_settle;
      S_RF:     limit = cfg_rf_settle;
      S_SW:     limit = cfg_clk_switch;
      S_LISTEN: limit = cfg_listen;
      default:  limit = '0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_SLEEP:  if (expired) nxt = after_sleep;
      S_BB:     if (expired) nxt = after_bb;
      S_RF:     if (expired) nxt = after_rf;
      S_SW:     if (expired) nxt = S_LISTEN;
      S_LISTEN: if (det_seen) nxt = S_PRE;
                else if (expired) nxt = S_SLEEP;
      S_PRE:    if (det_fail || det_ok) nxt = det_fail ? S_SLEEP : S_CORR;
      S_CORR:   if (corr_done) nxt = S_SLEEP;
      default:  nxt = S_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_SLEEP;
      cnt        <= '0;
      status     <= ST_NONE;
      det_abort  <= 1'b0;
      corr_start <= 1'b0;
      wake_irq   <= 1'b0;
    end else begin
      state      <= nxt;
      cnt        <= (nxt != state) ? '0 : cnt_inc[CNT_W-1:0];
      det_abort  <= 1'b0;
      corr_start <= 1'b0;
      wake_irq   <= 1'b0;
      if (state == S_LISTEN && nxt == S_SLEEP) begin
        status    <= ST_TIMEOUT;
        det_abort <= 1'b1;
      end
      if (state == S_PRE && nxt == S_SLEEP) status <= ST_PREFAIL;
      if (state == S_PRE && nxt == S_CORR) corr_start <= 1'b1;
      if (state == S_CORR && corr_done) begin
        status   <= corr_match ? ST_MATCH : ST_MISS;
        wake_irq <= corr_match;
      end
    end
  end

  assign bb_en    = state != S_SLEEP;
  assign rf_en    = state inside {S_RF, S_SW, S_LISTEN, S_PRE, S_CORR};
  assign cmp_en   = rf_en;
  assign fast_clk = state inside {S_SW, S_LISTEN, S_PRE, S_CORR};
  assign det_en   = state inside {S_LISTEN, S_PRE};
  assign uart_en  = state == S_CORR;

  assert_sleep_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SLEEP |-> !bb_en && !rf_en && !cmp_en && !fast_clk && !uart_en);

  assert_listen_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LISTEN |-> (cnt == '0 || cnt_inc <= {1'b0, cfg_listen}));

  assert_abort_powered_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    det_abort |-> !bb_en && !rf_en && !det_en && status == ST_TIMEOUT);

  assert_decode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE && !det_ok && !det_fail) |=> bb_en && rf_en && cmp_en && fast_clk);

  assert_uart_powered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uart_en |-> bb_en && rf_en && cmp_en && fast_clk && !det_en);

  assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> status == ST_MATCH && !uart_en && !bb_en);

  assert_corr_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    corr_start |-> uart_en && $past(det_ok));

endmodule

// File: tb/wake_sequencer_test.sv
module wake_sequencer_test;
  localparam int CNT_W = 32;
  localparam int NV = 6;
  // fields: sleep, bb, rf, sw, listen, mode(0 timeout,1 prefail,2 mismatch,3 match), delay, exp status
  localparam int VEC [NV][8] = '{
    '{3, 4, 2, 1, 5, 0, 0, 1},
    '{1, 2, 3, 2, 4, 3, 1, 4},
    '{5, 0, 2, 1, 3, 2, 2, 3},
    '{2, 3, 0, 0, 6, 1, 0, 2},
    '{0, 1, 1, 1, 2, 3, 1, 4},
    '{4, 0, 0, 0, 1, 0, 0, 1}
  };

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] cfg_sleep = 3, cfg_bb_settle = 1, cfg_rf_settle = 1, cfg_clk_switch = 1, cfg_listen = 2;
  logic det_seen = 0, det_ok = 0, det_fail = 0, corr_done = 0, corr_match = 0;
  logic bb_en, rf_en, cmp_en, fast_clk, det_en, det_abort, corr_start, uart_en, wake_irq;
  logic [2:0] status;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wake_sequencer #(.CNT_W(CNT_W)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit held;
    // reset state
    step(); step();
    chk(!bb_en && !rf_en && !cmp_en && !fast_clk && !det_en && !uart_en, "R1", bb_en, 0);
    chk(status == 0, "R10", status, 0);

    for (int v = 0; v < NV; v++) begin
      rst_n = 0;
      cfg_sleep = VEC[v][0]; cfg_bb_settle = VEC[v][1]; cfg_rf_settle = VEC[v][2];
      cfg_clk_switch = VEC[v][3]; cfg_listen = VEC[v][4];
      step(); rst_n = 1;
      n = 0; while (!bb_en && !rf_en && n < 1000) begin step(); n++; end
      chk(n == mx1(VEC[v][0]), "R1", n, mx1(VEC[v][0]));
      n = 0; while (bb_en && !rf_en && n < 1000) begin step(); n++; end
      chk(n == VEC[v][1], VEC[v][1] == 0 ? "R5" : "R2", n, VEC[v][1]);
      chk(rf_en == cmp_en, "R3", cmp_en, rf_en);
      n = 0; while (rf_en && !fast_clk && n < 1000) begin step(); n++; end
      chk(n == VEC[v][2], VEC[v][2] == 0 ? "R5" : "R3", n, VEC[v][2]);
      n = 0; while (fast_clk && !det_en && n < 1000) begin step(); n++; end
      chk(n == VEC[v][3], VEC[v][3] == 0 ? "R5" : "R4", n, VEC[v][3]);
      if (VEC[v][5] == 0) begin
        n = 0; while (det_en && n < 1000) begin step(); n++; end
        chk(n == mx1(VEC[v][4]), "R6", n, mx1(VEC[v][4]));
        chk(det_abort && !bb_en && !rf_en && !fast_clk && status == 1, "R6", status, 1);
        step();
        chk(!det_abort, "R6", det_abort, 0);
      end else begin
        for (int i = 0; i < VEC[v][6]; i++) step();
        det_seen = 1; step(); det_seen = 0;
        held = 1;
        for (int i = 0; i < VEC[v][4] + 3; i++) begin
          if (!(bb_en && rf_en && cmp_en && fast_clk && det_en)) held = 0;
          step();
        end
        chk(held, "R7", held, 1);
        if (VEC[v][5] == 1) begin
          det_fail = 1; det_ok = 1; step(); det_fail = 0; det_ok = 0;
          chk(!bb_en && !rf_en && !uart_en && !corr_start && status == 2, "R8", status, 2);
        end else begin
          det_ok = 1; step(); det_ok = 0;
          chk(corr_start && uart_en && !det_en, "R9", corr_start, 1);
          step();
          chk(!corr_start && uart_en && bb_en, "R9", corr_start, 0);
          for (int i = 0; i < VEC[v][4] + 2; i++) step();
          chk(uart_en && rf_en && fast_clk, "R7", uart_en, 1);
          corr_match = (VEC[v][5] == 3); corr_done = 1; step(); corr_done = 0; corr_match = 0;
          chk(!uart_en && !bb_en && !rf_en && !fast_clk, "R9", uart_en, 0);
          chk(status == VEC[v][7], "R10", status, VEC[v][7]);
          chk(wake_irq == (VEC[v][5] == 3), "R9", wake_irq, VEC[v][5] == 3);
          step();
          chk(!wake_irq, "R9", wake_irq, 0);
        end
      end
      // sleep period after return
      n = (VEC[v][5] == 0 || VEC[v][5] >= 2) ? 1 : 0;
      while (!bb_en && !rf_en && n < 1000) begin step(); n++; end
      chk(n == mx1(VEC[v][0]), "R1", n, mx1(VEC[v][0]));
    end

    // directed: det_seen on the last window cycle together with expiry
    rst_n = 0; cfg_sleep = 2; cfg_bb_settle = 1; cfg_rf_settle = 1; cfg_clk_switch = 1; cfg_listen = 3;
    step(); rst_n = 1;
    while (!det_en) step();
    step(); step();
    det_seen = 1; step(); det_seen = 0;
    chk(det_en && bb_en && !det_abort, "R7", det_en, 1);
    det_ok = 1; step(); det_ok = 0;
    corr_done = 1; corr_match = 0; step(); corr_done = 0;
    chk(status == 3 && !wake_irq, "R10", status, 3);

    // directed: reset in the middle of decoding clears everything
    while (!det_en) step();
    det_seen = 1; step(); det_seen = 0;
    rst_n = 0; #1;
    chk(!bb_en && !uart_en && status == 0, "R1", status, 0);
    step(); rst_n = 1; step();
    chk(!bb_en && !fast_clk, "R1", bb_en, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule